// File: doc/BRIEF.md
# Natural-Order Reorder, DC-Centring Shift and Cyclic-Prefix Inserter

This block sits behind a pipelined transform engine whose results leave in bit-reversed index order. It collects one frame of signed complex samples, each 16-bit real and 16-bit imaginary, into a two-bank frame store. While the next frame is being written, it reads the stored frame back in natural bin order. Optionally it rotates the frame by half its length so that the zero-frequency bin lands in the middle. Before the frame body it emits a cyclic prefix: a copy of the last L samples of the frame as it will be sent.

The prefix length is taken per symbol from a small programmable schedule. The schedule either wraps around or runs out, after which no further prefixes are added. A simple write-only register port sets the frame size exponent, the shift enable, the wrap mode, the schedule length and the schedule entries. Samples move one per clock on valid/ready streams. The output marks the final sample of every symbol.

Top module: `ofdm_reorder_cp`

## Requirements
- R1: The j-th sample accepted for a frame of size N = 2^m holds bin bitrev_m(j), where bitrev_m reverses the low m bits of j. After any prefix, the output frame body lists bins 0, 1, ..., N-1 in that order when the shift is off.
- R2: The size register (register address 0, full 16-bit write value) sets m, and each frame is exactly 2^m input samples. A write of 0 gives m = 1, and a write above MAX_LOG2 gives m = MAX_LOG2.
- R3: With the shift register (address 1, bit 0) set to 1, body position n carries bin (n + N/2) mod N.
- R4: A symbol with prefix length L outputs first the last L samples of its body order, then the N body samples. An L larger than N is treated as N.
- R5: The schedule entry with index i sits at register address 2^LIST_LOG2 + i, with its value in bits [MAX_LOG2:0]. The schedule length sits at address 2, and writes above 2^LIST_LOG2 clamp to that value. Each symbol takes L from the entry at the schedule pointer, and L is 0 while the length is 0.
- R6: With the wrap register (address 3, bit 0) at 1, the pointer returns to entry 0 after entry length-1. At 0, once the last used entry has been taken, every later symbol has L = 0.
- R7: Any write to a schedule entry, to the schedule length or to the wrap register returns the pointer to entry 0 and re-arms a finished non-wrapping schedule.
- R8: out_last is 1 exactly on the final of the L+N output samples of each symbol.
- R9: The size, shift and prefix length of a frame are fixed when its first input sample is accepted. Register writes during the frame affect only later frames.
- R10: A second frame is accepted while the first is still unread. in_ready is low only when both banks hold unread frames. While out_valid is high and out_ready is low, out_valid and out_data hold.
- R11: After reset, out_valid is 0 and in_ready is 1. The settings are m = MAX_LOG2, shift off, schedule length 0 and wrap on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | LIST_LOG2+1 | Register address; top bit set selects a schedule entry |
| cfg_wdata | input | 16 | Register write value |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | 2*COMP_W | Input sample, real in upper half, imaginary in lower half |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | 2*COMP_W | Output sample, same packing as the input |
| out_last | output | 1 | Final sample of the current symbol |

## Verification
The bench builds the block with MAX_LOG2 = 4 and LIST_LOG2 = 2. This keeps every frame size from 2 to 16 points, and both clamps of the size register, within a few hundred cycles. The four-entry schedule lets the bench reach wrap-around, exhaustion in non-wrapping mode and a pointer reset within a handful of symbols. An entry value of 20, which exceeds every frame size, exercises the prefix clamp. With two banks of at most 16 samples, filling both banks under a stalled output and then probing the input stall takes only a few dozen cycles.

// File: rtl/ofdm_rcp_pkg.sv
package ofdm_rcp_pkg;

   // Register map, low address bits, when the entry-select bit is clear
   localparam logic [1:0] REG_SIZE  = 2'd0;
   localparam logic [1:0] REG_SHIFT = 2'd1;
   localparam logic [1:0] REG_LEN   = 2'd2;
   localparam logic [1:0] REG_WRAP  = 2'd3;

   // Reverse the low m bits of j (1 <= m <= 16)
   function automatic logic [15:0] bitrev_m(input logic [15:0] j, input logic [4:0] m);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = j[15-i];
      return r >> (5'd16 - m);
   endfunction

endpackage

// File: rtl/rsc_cp_list.sv
module rsc_cp_list #(
   parameter int LIST_LOG2 = 3,
   parameter int LW        = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_entry,
   input  logic                 we_len,
   input  logic                 we_wrap,
   input  logic [LIST_LOG2-1:0] idx,
   input  logic [15:0]          wdata,
   input  logic                 wrap_mode,
   input  logic                 take,
   output logic [LW-1:0]        cur_len
);
   localparam int DEPTH = 1 << LIST_LOG2;

   logic [LW-1:0]        ent [DEPTH];
   logic [LIST_LOG2:0]   len;
   logic [LIST_LOG2-1:0] ptr;
   logic                 spent;
   logic                 live, ptr_end, touch;

   assign touch   = we_entry | we_len | we_wrap;
   assign live    = (len != '0) && !spent;
   assign ptr_end = ({1'b0, ptr} == len - 1'b1);
   assign cur_len = live ? ent[ptr] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
         len   <= '0;
         ptr   <= '0;
         spent <= 1'b0;
      end else begin
         if (we_entry) ent[idx] <= LW'(wdata);
         if (we_len)
            len <= (wdata > 16'(DEPTH)) ? (LIST_LOG2+1)'(DEPTH) : (LIST_LOG2+1)'(wdata);
         if (touch) begin
            ptr   <= '0;
            spent <= 1'b0;
         end else if (take && live) begin
            if (ptr_end) begin
               if (wrap_mode) ptr <= '0;
               else           spent <= 1'b1;
            end else begin
               ptr <= ptr + 1'b1;
            end
         end
      end
   end

   // R6: wrapping schedule restarts at entry 0 after its last used entry
   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take && live && ptr_end && wrap_mode && !touch |=> ptr == '0);
   // R6: an exhausted schedule stays exhausted until a register write
   assert_spent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      spent && !touch |=> cur_len == '0);
   // R7: any schedule write returns the pointer to entry 0
   assert_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      touch |=> ptr == '0 && !spent);

endmodule

// File: rtl/rsc_wr_ctrl.sv
module rsc_wr_ctrl
   import ofdm_rcp_pkg::*;
#(
   parameter int MAX_LOG2 = 8,
   parameter int MW       = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  logic [MW-1:0]       cfg_m,
   output logic [MAX_LOG2-1:0] addr,
   output logic                first,
   output logic                frame_end,
   output logic [MW-1:0]       eff_m
);
   logic [MAX_LOG2-1:0] idx;
   logic [MW-1:0]       lat_m;
   logic [MAX_LOG2:0]   last_idx;

   assign first     = (idx == '0);
   assign eff_m     = first ? cfg_m : lat_m;
   assign last_idx  = ((MAX_LOG2+1)'(1) << eff_m) - 1'b1;
   assign frame_end = ({1'b0, idx} == last_idx);
   assign addr      = (MAX_LOG2)'(bitrev_m(16'(idx), 5'(eff_m)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx   <= '0;
         lat_m <= '0;
      end else if (fire) begin
         if (first) lat_m <= cfg_m;
         idx <= frame_end ? '0 : idx + 1'b1;
      end
   end

   // R2: a frame of 2^m samples closes and the next one starts from index 0
   assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire && frame_end |=> first);
   // R9: the size of a frame in progress does not follow later writes
   assert_size_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !frame_end |=> eff_m == $past(eff_m));

endmodule

// File: rtl/rsc_rd_ctrl.sv
module rsc_rd_ctrl #(
   parameter int MAX_LOG2 = 8,
   parameter int MW       = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid,
   input  logic                ready,
   input  logic [MW-1:0]       m,
   input  logic                shift,
   input  logic [MAX_LOG2:0]   cp_len,
   output logic [MAX_LOG2-1:0] addr,
   output logic                last,
   output logic                done
);
   localparam int CW = MAX_LOG2 + 2;

   logic [CW-1:0] cnt, nval, lval, total_m1, n, bin;

   assign nval     = CW'(1) << m;
   assign lval     = CW'(cp_len);
   assign total_m1 = lval + nval - CW'(1);
   // position in the body order: prefix walks the tail, then the whole body
   assign n        = (cnt < lval) ? (nval - lval + cnt) : (cnt - lval);
   assign bin      = shift ? (n ^ (nval >> 1)) : n;
   assign addr     = (MAX_LOG2)'(bin);
   assign last     = (cnt == total_m1);
   assign done     = valid && ready && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (valid && ready) cnt <= last ? '0 : cnt + 1'b1;
   end

   // R8: after the marked final sample the next symbol starts from position 0
   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cnt == '0);
   // R10: a stalled output does not advance
   assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> $stable(cnt));

endmodule

// File: rtl/ofdm_reorder_cp.sv
module ofdm_reorder_cp
   import ofdm_rcp_pkg::*;
#(
   parameter int MAX_LOG2  = 8,
   parameter int LIST_LOG2 = 3,
   parameter int COMP_W    = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [LIST_LOG2:0]    cfg_addr,
   input  logic [15:0]           cfg_wdata,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [2*COMP_W-1:0]   in_data,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [2*COMP_W-1:0]   out_data,
   output logic                  out_last
);
   localparam int MW   = $clog2(MAX_LOG2 + 1);
   localparam int LW   = MAX_LOG2 + 1;
   localparam int DW   = 2 * COMP_W;
   localparam int NMAX = 1 << MAX_LOG2;

   if (MAX_LOG2 < 1 || MAX_LOG2 > 16) begin : g_bad_size
      $error("MAX_LOG2 must lie in 1..16");
   end
   if (LIST_LOG2 < 2) begin : g_bad_list
      $error("LIST_LOG2 must be at least 2 to leave room for the control registers");
   end

   // ---------------- register port ----------------
   logic          sel_ent, we_size, we_shift, we_len, we_wrap, we_entry;
   logic [MW-1:0] cfg_m;
   logic          cfg_shift, cfg_wrap;

   assign sel_ent  = cfg_addr[LIST_LOG2];
   assign we_entry = cfg_we &&  sel_ent;
   assign we_size  = cfg_we && !sel_ent && (cfg_addr[1:0] == REG_SIZE);
   assign we_shift = cfg_we && !sel_ent && (cfg_addr[1:0] == REG_SHIFT);
   assign we_len   = cfg_we && !sel_ent && (cfg_addr[1:0] == REG_LEN);
   assign we_wrap  = cfg_we && !sel_ent && (cfg_addr[1:0] == REG_WRAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_m     <= MW'(MAX_LOG2);
         cfg_shift <= 1'b0;
         cfg_wrap  <= 1'b1;
      end else begin
         if (we_size) begin
            if (cfg_wdata == '0)                   cfg_m <= MW'(1);
            else if (cfg_wdata > 16'(MAX_LOG2))    cfg_m <= MW'(MAX_LOG2);
            else                                   cfg_m <= MW'(cfg_wdata);
         end
         if (we_shift) cfg_shift <= cfg_wdata[0];
         if (we_wrap)  cfg_wrap  <= cfg_wdata[0];
      end
   end

   // ---------------- write side ----------------
   logic                wr_fire, wr_first, wr_end, wr_bank, take;
   logic [MAX_LOG2-1:0] wr_addr;
   logic [MW-1:0]       wr_m;
   logic [LW-1:0]       cur_len, nval_w, l_take;

   assign wr_fire = in_valid && in_ready;
   assign take    = wr_fire && wr_first;

   rsc_wr_ctrl #(.MAX_LOG2(MAX_LOG2), .MW(MW)) u_wr (
      .clk(clk), .rst_n(rst_n), .fire(wr_fire), .cfg_m(cfg_m),
      .addr(wr_addr), .first(wr_first), .frame_end(wr_end), .eff_m(wr_m));

   rsc_cp_list #(.LIST_LOG2(LIST_LOG2), .LW(LW)) u_list (
      .clk(clk), .rst_n(rst_n), .we_entry(we_entry), .we_len(we_len),
      .we_wrap(we_wrap), .idx(cfg_addr[LIST_LOG2-1:0]), .wdata(cfg_wdata),
      .wrap_mode(cfg_wrap), .take(take), .cur_len(cur_len));

   assign nval_w = LW'(1) << wr_m;
   assign l_take = (cur_len > nval_w) ? nval_w : cur_len;

   // ---------------- frame store and per-bank settings ----------------
   logic [DW-1:0] mem [2*NMAX];
   logic [MW-1:0] meta_m  [2];
   logic          meta_sh [2];
   logic [LW-1:0] meta_l  [2];
   logic [1:0]    bank_full;
   logic          rd_bank, rd_done;
   logic [MAX_LOG2-1:0] rd_addr;

   always_ff @(posedge clk) begin
      if (wr_fire) mem[{wr_bank, wr_addr}] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++) begin
            meta_m[b]  <= '0;
            meta_sh[b] <= 1'b0;
            meta_l[b]  <= '0;
         end
         wr_bank <= 1'b0;
         rd_bank <= 1'b0;
      end else begin
         if (take) begin
            meta_m[wr_bank]  <= wr_m;
            meta_sh[wr_bank] <= cfg_shift;
            meta_l[wr_bank]  <= l_take;
         end
         if (wr_fire && wr_end) wr_bank <= ~wr_bank;
         if (rd_done)           rd_bank <= ~rd_bank;
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    bank_full[b] <= 1'b0;
         else if (wr_fire && wr_end && wr_bank == 1'(b)) bank_full[b] <= 1'b1;
         else if (rd_done && rd_bank == 1'(b))          bank_full[b] <= 1'b0;
      end
   end

   assign in_ready  = !bank_full[wr_bank];
   assign out_valid = bank_full[rd_bank];

   // ---------------- read side ----------------
   rsc_rd_ctrl #(.MAX_LOG2(MAX_LOG2), .MW(MW)) u_rd (
      .clk(clk), .rst_n(rst_n), .valid(out_valid), .ready(out_ready),
      .m(meta_m[rd_bank]), .shift(meta_sh[rd_bank]), .cp_len(meta_l[rd_bank]),
      .addr(rd_addr), .last(out_last), .done(rd_done));

   assign out_data = mem[{rd_bank, rd_addr}];

   // R10: the bank being filled is never the bank being drained
   assert_bank_sep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && wr_fire |-> wr_bank != rd_bank);
   // R10: input stalls only when both banks hold unread frames
   assert_stall_only_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> bank_full == 2'b11);
   // R10: a held output keeps its sample
   assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
   // R4: a taken prefix never exceeds the frame length
   assert_cp_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> meta_l[$past(wr_bank)] <= (LW'(1) << meta_m[$past(wr_bank)]));

endmodule

// File: tb/ofdm_reorder_cp_tb.sv
module ofdm_reorder_cp_tb;
   localparam int MAXL = 4;
   localparam int KL   = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [2:0]  cfg_addr;
   logic [15:0] cfg_wdata;
   logic        in_valid, in_ready;
   logic [31:0] in_data;
   logic        out_valid, out_ready, out_last;
   logic [31:0] out_data;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   ofdm_reorder_cp #(.MAX_LOG2(MAXL), .LIST_LOG2(KL), .COMP_W(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last));

   function automatic int brev(int j, int m);
      int r = 0;
      for (int i = 0; i < m; i++) r |= ((j >> i) & 1) << (m - 1 - i);
      return r;
   endfunction

   function automatic logic [31:0] smp(int seed, int bin);
      logic [15:0] re;
      re = 16'(seed * 32 + bin);
      return {re, ~re};
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic cfg_write(int addr, int val);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = 3'(addr);
      cfg_wdata = 16'(val);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic send(int m, int seed);
      for (int j = 0; j < (1 << m); j++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = smp(seed, brev(j, m));
         while (!in_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic recv(int m, int sh, int cpl, int seed, int thr, string tag);
      int nn = 1 << m;
      int tot = cpl + nn;
      int p = 0, derr = 0, lerr = 0, cyc = 0;
      logic [31:0] fa = '0, fe = '0, e;
      while (p < tot) begin
         @(negedge clk);
         cyc++;
         out_ready = (thr == 0) || (cyc % 3 != 0);
         if (out_valid && out_ready) begin
            int n, bin;
            n   = (p < cpl) ? (nn - cpl + p) : (p - cpl);
            bin = (sh != 0) ? ((n + nn / 2) % nn) : n;
            e   = smp(seed, bin);
            if (out_data !== e) begin
               if (derr == 0) begin fa = out_data; fe = e; end
               derr++;
            end
            if (out_last !== (p == tot - 1)) lerr++;
            p++;
         end
      end
      @(negedge clk);
      out_ready = 1'b0;
      chk(derr == 0, tag, "symbol sample", fa, fe);
      chk(lerr == 0, "R8", "last marker errors", 32'(lerr), 32'd0);
   endtask

   task automatic t_reset;
      chk(out_valid == 1'b0, "R11", "out_valid after reset", 32'(out_valid), 32'd0);
      chk(in_ready == 1'b1, "R11", "in_ready after reset", 32'(in_ready), 32'd1);
      send(4, 1);
      recv(4, 0, 0, 1, 0, "R11");
   endtask

   task automatic t_natural;
      cfg_write(0, 3);
      fork
         send(3, 2);
         recv(3, 0, 0, 2, 1, "R1");
      join
      cfg_write(0, 0);          // R2: clamps to m = 1
      send(1, 3);
      recv(1, 0, 0, 3, 0, "R2");
      cfg_write(0, 9);          // R2: clamps to m = MAX
      send(4, 4);
      recv(4, 0, 0, 4, 0, "R2");
   endtask

   task automatic t_shift;
      cfg_write(1, 1);
      send(4, 5);
      recv(4, 1, 0, 5, 0, "R3");
      cfg_write(0, 2);
      send(2, 6);
      recv(2, 1, 0, 6, 1, "R3");
      cfg_write(1, 0);
   endtask

   task automatic t_cp_wrap;
      cfg_write(0, 3);
      cfg_write(4, 2);
      cfg_write(5, 5);
      cfg_write(2, 2);
      cfg_write(3, 1);
      fork
         begin send(3, 10); send(3, 11); send(3, 12); end
         begin
            recv(3, 0, 2, 10, 1, "R5");
            recv(3, 0, 5, 11, 1, "R4");
            recv(3, 0, 2, 12, 1, "R6");
         end
      join
   endtask

   task automatic t_cp_stop;
      cfg_write(3, 0);
      cfg_write(4, 3);
      cfg_write(2, 1);
      send(3, 20);
      recv(3, 0, 3, 20, 0, "R6");
      send(3, 21);
      recv(3, 0, 0, 21, 0, "R6");
      // R4: entry of 20 with N = 4 is cut to 4
      cfg_write(3, 1);
      cfg_write(4, 20);
      cfg_write(0, 2);
      send(2, 22);
      recv(2, 0, 4, 22, 0, "R4");
      cfg_write(1, 1);
      send(2, 23);
      recv(2, 1, 4, 23, 0, "R4");
      cfg_write(1, 0);
      cfg_write(2, 0);
   endtask

   task automatic t_rewind;
      cfg_write(4, 1);
      cfg_write(5, 2);
      cfg_write(6, 3);
      cfg_write(2, 3);
      cfg_write(0, 2);
      send(2, 30);
      recv(2, 0, 1, 30, 0, "R5");
      cfg_write(2, 3);
      send(2, 31);
      recv(2, 0, 1, 31, 0, "R7");
      send(2, 32);
      recv(2, 0, 2, 32, 0, "R7");
      cfg_write(2, 0);
   endtask

   task automatic t_boundary;
      cfg_write(0, 3);
      cfg_write(1, 0);
      fork
         send(3, 40);
         begin
            repeat (3) @(posedge clk);
            cfg_write(0, 2);
            cfg_write(1, 1);
         end
      join
      send(2, 41);
      recv(3, 0, 0, 40, 0, "R9");
      recv(2, 1, 0, 41, 0, "R9");
      cfg_write(1, 0);
   endtask

   task automatic t_backpressure;
      cfg_write(0, 2);
      send(2, 50);
      send(2, 51);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = smp(52, 0);
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b0, "R10", "in_ready with both banks full", 32'(in_ready), 32'd0);
      chk(out_valid == 1'b1, "R10", "out_valid held", 32'(out_valid), 32'd1);
      chk(out_data == smp(50, 0), "R10", "held sample", out_data, smp(50, 0));
      in_valid = 1'b0;
      recv(2, 0, 0, 50, 0, "R10");
      recv(2, 0, 0, 51, 1, "R10");
   endtask

   initial begin
      rst_n     = 1'b0;
      cfg_we    = 1'b0;
      cfg_addr  = '0;
      cfg_wdata = '0;
      in_valid  = 1'b0;
      in_data   = '0;
      out_ready = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_natural();
      t_shift();
      t_cp_wrap();
      t_cp_stop();
      t_rewind();
      t_boundary();
      t_backpressure();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule